// File: doc/BRIEF.md
# Hardware Breakpoint Status and Control Unit

This unit keeps the status word and the control word that govern four hardware breakpoints. External address comparators send one match pulse per breakpoint. The instruction pipeline reports three things: single-step completion with the current trap flag, task switches with the incoming task's trap bit, and decoded instructions that touch the debug register file. From these inputs the unit latches sticky status bits, drops the per-task enables on a task switch, and raises a one-cycle debug-exception request or undefined-opcode request.

Access to the debug register file is screened before it takes effect. When the general-detect enable is set, any access is trapped and suppressed. When debug extensions are on, register numbers 4 and 5 are illegal. When debug extensions are off, those numbers alias registers 6 and 7. Reads return data only for the status and control words; the comparator address registers live outside this unit.

Top module: `brkpt_ctl_unit`

## Requirements
- R1: A match pulse on bp_hit[i] sets status bit i (bits 0 to 3) on the next clock, whether or not breakpoint i is enabled.
- R2: dbg_exc is high in the cycle after a match on breakpoint i only if control bit 2i (per-task enable) or control bit 2i+1 (persistent enable) is 1; either enable alone is enough.
- R3: A task_sw pulse clears control bits 0, 2, 4 and 6 on the next clock and leaves bits 1, 3, 5, 7 and 13 unchanged.
- R4: step_done while trap_flag is 1 sets status bit 14 and raises dbg_exc the next cycle; step_done with trap_flag 0 does neither.
- R5: task_sw with task_trap 1 sets status bit 15 and raises dbg_exc the next cycle.
- R6: When control bit 13 is 1, a valid access (dr_vld) to any register number 0 to 7 sets status bit 13 and raises dbg_exc the next cycle; acc_go stays low, rd_data is 0 and neither register changes through that access.
- R7: With dbg_ext 1, a valid access to register number 4 or 5 raises ud_req the next cycle, keeps acc_go low, changes no register and raises no debug exception of its own, even when control bit 13 is 1.
- R8: With dbg_ext 0, register number 4 accesses the status word and number 5 the control word, exactly as numbers 6 and 7 do.
- R9: Reset clears both words and both requests. Status bits change only by reset, by an event, or by a permitted write to register 6; a write replaces the writable bits, and events in the same cycle are OR-ed on top.
- R10: Several events in one cycle set all of their status bits together and give a single dbg_exc pulse one cycle long.
- R11: Only status bits 0 to 3 and 13 to 15 and control bits 0 to 7 and 13 are storable; every other bit reads 0. A read with acc_go high returns the addressed word on rd_data in the same cycle; otherwise rd_data is 0.
- R12: When a task switch and a permitted control write fall in the same cycle, the written value is stored with bits 0, 2, 4 and 6 forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bp_hit | input | 4 | Per-breakpoint match pulses from comparators |
| step_done | input | 1 | An instruction completed successfully |
| trap_flag | input | 1 | Single-step trap flag from the flags word |
| task_sw | input | 1 | A task switch is taking place |
| task_trap | input | 1 | Trap bit of the incoming task |
| dr_vld | input | 1 | A decoded debug register access is presented |
| dr_wr | input | 1 | 1 = write (store), 0 = read (load) |
| dr_idx | input | 3 | Debug register number 0 to 7 |
| dr_wdata | input | 32 | Write data |
| dbg_ext | input | 1 | Debug extensions enable from the mode control word |
| acc_go | output | 1 | The presented access may proceed |
| rd_data | output | 32 | Read data for a permitted read of status or control |
| dbg_exc | output | 1 | Debug exception request pulse |
| ud_req | output | 1 | Undefined-opcode request pulse |
| stat_reg | output | 32 | Current status word |
| ctl_reg | output | 32 | Current control word |

## Verification
The general-detect trap and the breakpoint match can fall in the same cycle, because the trap fires while the comparators are still reporting. The bench provokes this by arming general detect and a per-task enable. It then presents, in one cycle, a blocked control write, two breakpoint matches, a single-step completion and a trapping task switch. It judges the outcome from the status word: all five bits must be set together, the control word must lose only its per-task enable while the blocked write leaves no trace, and dbg_exc must be high for exactly one cycle.

// File: rtl/brk_pkg.sv
package brk_pkg;
    localparam int DATA_W  = 32;
    localparam int IDX_W   = 3;
    localparam int BD_BIT  = 13;
    localparam int BS_BIT  = 14;
    localparam int BT_BIT  = 15;
    localparam int GD_BIT  = 13;
    localparam logic [IDX_W-1:0] STAT_IDX = 3'd6;
    localparam logic [IDX_W-1:0] CTL_IDX  = 3'd7;

    typedef struct packed {
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] ctl;
        logic              exc;
        logic              ud;
    } brk_state_t;

    function automatic logic [DATA_W-1:0] stat_mask(int nbp);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < nbp; i++) m[i] = 1'b1;
        m[BD_BIT] = 1'b1;
        m[BS_BIT] = 1'b1;
        m[BT_BIT] = 1'b1;
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] ctl_mask(int nbp);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < 2*nbp; i++) m[i] = 1'b1;
        m[GD_BIT] = 1'b1;
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] local_mask(int nbp);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < nbp; i++) m[2*i] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/brk_enable_decode.sv
module brk_enable_decode #(
    parameter int NUM_BP = 4
) (
    input  logic [2*NUM_BP-1:0] ctl_en_bits,
    output logic [NUM_BP-1:0]   bp_en
);
    for (genvar i = 0; i < NUM_BP; i++) begin : g_en
        // per-task enable or persistent enable
        assign bp_en[i] = ctl_en_bits[2*i] | ctl_en_bits[2*i+1];
    end
endmodule

// File: rtl/brk_access_decode.sv
module brk_access_decode
    import brk_pkg::*;
(
    input  logic             acc_vld,
    input  logic             acc_wr,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic             ext_on,
    input  logic             gd_on,
    output logic             ud_hit,
    output logic             bd_trap,
    output logic             go,
    output logic             wr_stat,
    output logic             wr_ctl,
    output logic             rd_stat,
    output logic             rd_ctl
);
    logic             alias_zone;
    logic [IDX_W-1:0] eff_idx;

    always_comb begin
        alias_zone = (acc_idx == 3'd4) || (acc_idx == 3'd5);
        eff_idx    = acc_idx;
        if (!ext_on && alias_zone) eff_idx = {2'b11, acc_idx[0]};
        ud_hit  = acc_vld && ext_on && alias_zone;
        bd_trap = acc_vld && !ud_hit && gd_on;
        go      = acc_vld && !ud_hit && !gd_on;
        wr_stat = go &&  acc_wr && (eff_idx == STAT_IDX);
        wr_ctl  = go &&  acc_wr && (eff_idx == CTL_IDX);
        rd_stat = go && !acc_wr && (eff_idx == STAT_IDX);
        rd_ctl  = go && !acc_wr && (eff_idx == CTL_IDX);
    end
endmodule

// File: rtl/brk_event_merge.sv
module brk_event_merge
    import brk_pkg::*;
#(
    parameter int NUM_BP = 4
) (
    input  logic [NUM_BP-1:0] bp_hit,
    input  logic [NUM_BP-1:0] bp_en,
    input  logic              step_done,
    input  logic              trap_flag,
    input  logic              task_sw,
    input  logic              task_trap,
    input  logic              bd_trap,
    output logic [DATA_W-1:0] set_bits,
    output logic              exc_any
);
    logic bs_ev, bt_ev;

    always_comb begin
        bs_ev    = step_done && trap_flag;
        bt_ev    = task_sw && task_trap;
        set_bits = '0;
        set_bits[NUM_BP-1:0] = bp_hit;
        set_bits[BD_BIT] = bd_trap;
        set_bits[BS_BIT] = bs_ev;
        set_bits[BT_BIT] = bt_ev;
        exc_any  = (|(bp_hit & bp_en)) || bs_ev || bt_ev || bd_trap;
    end
endmodule

// File: rtl/brkpt_ctl_unit.sv
module brkpt_ctl_unit
    import brk_pkg::*;
#(
    parameter int NUM_BP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_BP-1:0] bp_hit,
    input  logic              step_done,
    input  logic              trap_flag,
    input  logic              task_sw,
    input  logic              task_trap,
    input  logic              dr_vld,
    input  logic              dr_wr,
    input  logic [IDX_W-1:0]  dr_idx,
    input  logic [DATA_W-1:0] dr_wdata,
    input  logic              dbg_ext,
    output logic              acc_go,
    output logic [DATA_W-1:0] rd_data,
    output logic              dbg_exc,
    output logic              ud_req,
    output logic [DATA_W-1:0] stat_reg,
    output logic [DATA_W-1:0] ctl_reg
);
    localparam logic [DATA_W-1:0] S_MASK = stat_mask(NUM_BP);
    localparam logic [DATA_W-1:0] C_MASK = ctl_mask(NUM_BP);
    localparam logic [DATA_W-1:0] L_MASK = local_mask(NUM_BP);
    localparam logic [DATA_W-1:0] G_MASK = C_MASK & ~L_MASK;

    brk_state_t st_d, st_q;

    logic [NUM_BP-1:0] bp_en;
    logic ud_hit, bd_trap, wr_stat, wr_ctl, rd_stat, rd_ctl;
    logic [DATA_W-1:0] set_bits;
    logic exc_any;

    brk_enable_decode #(.NUM_BP(NUM_BP)) u_en (
        .ctl_en_bits (st_q.ctl[2*NUM_BP-1:0]),
        .bp_en       (bp_en)
    );

    brk_access_decode u_acc (
        .acc_vld (dr_vld),
        .acc_wr  (dr_wr),
        .acc_idx (dr_idx),
        .ext_on  (dbg_ext),
        .gd_on   (st_q.ctl[GD_BIT]),
        .ud_hit  (ud_hit),
        .bd_trap (bd_trap),
        .go      (acc_go),
        .wr_stat (wr_stat),
        .wr_ctl  (wr_ctl),
        .rd_stat (rd_stat),
        .rd_ctl  (rd_ctl)
    );

    brk_event_merge #(.NUM_BP(NUM_BP)) u_ev (
        .bp_hit    (bp_hit),
        .bp_en     (bp_en),
        .step_done (step_done),
        .trap_flag (trap_flag),
        .task_sw   (task_sw),
        .task_trap (task_trap),
        .bd_trap   (bd_trap),
        .set_bits  (set_bits),
        .exc_any   (exc_any)
    );

    always_comb begin
        st_d = st_q;
        if (wr_stat) st_d.stat = dr_wdata & S_MASK;
        st_d.stat = st_d.stat | set_bits;
        if (wr_ctl)  st_d.ctl  = dr_wdata & C_MASK;
        if (task_sw) st_d.ctl  = st_d.ctl & ~L_MASK;
        st_d.exc = exc_any;
        st_d.ud  = ud_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_stat) rd_data = st_q.stat;
        if (rd_ctl)  rd_data = st_q.ctl;
    end

    assign dbg_exc  = st_q.exc;
    assign ud_req   = st_q.ud;
    assign stat_reg = st_q.stat;
    assign ctl_reg  = st_q.ctl;

    // R3
    l_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        task_sw |=> ((ctl_reg & L_MASK) == '0));
    // R3
    g_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (task_sw && !wr_ctl) |=> ((ctl_reg & G_MASK) == $past(ctl_reg & G_MASK)));
    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> ((stat_reg & $past(stat_reg)) == $past(stat_reg)));
    // R2
    bp_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(bp_hit & bp_en)) |=> dbg_exc);
    // R6
    bd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bd_trap |=> (dbg_exc && stat_reg[BD_BIT]));
    // R6
    bd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bd_trap |-> !acc_go);
    // R7
    ud_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ud_req |-> !$past(acc_go));
endmodule

// File: tb/sim_brkpt_ctl_unit.sv
`timescale 1ns/1ps
module sim_brkpt_ctl_unit;
    logic clk = 1'b0;
    logic rst_n;
    logic [3:0] bp_hit;
    logic step_done, trap_flag, task_sw, task_trap;
    logic dr_vld, dr_wr, dbg_ext;
    logic [2:0] dr_idx;
    logic [31:0] dr_wdata;
    logic acc_go, dbg_exc, ud_req;
    logic [31:0] rd_data, stat_reg, ctl_reg;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_stat, m_ctl;
    logic m_exc, m_ud;

    always #10 clk = ~clk;

    brkpt_ctl_unit u0 (
        .clk(clk), .rst_n(rst_n), .bp_hit(bp_hit), .step_done(step_done),
        .trap_flag(trap_flag), .task_sw(task_sw), .task_trap(task_trap),
        .dr_vld(dr_vld), .dr_wr(dr_wr), .dr_idx(dr_idx), .dr_wdata(dr_wdata),
        .dbg_ext(dbg_ext), .acc_go(acc_go), .rd_data(rd_data),
        .dbg_exc(dbg_exc), .ud_req(ud_req), .stat_reg(stat_reg), .ctl_reg(ctl_reg)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        bp_hit = 0; step_done = 0; trap_flag = 0; task_sw = 0; task_trap = 0;
        dr_vld = 0; dr_wr = 0; dr_idx = 0; dr_wdata = 0; dbg_ext = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_stat = 0; m_ctl = 0; m_exc = 0; m_ud = 0;
        chk("R9", "reset stat", stat_reg, 0);
        chk("R9", "reset ctl", ctl_reg, 0);
        chk("R9", "reset exc", {31'd0, dbg_exc}, 0);
        chk("R9", "reset ud", {31'd0, ud_req}, 0);
    endtask

    // One cycle: drive at negedge, check combinational outputs, clock, check state.
    task automatic apply(string req, logic [3:0] hit, logic sd, logic tf,
                         logic tsw, logic ttr, logic vld, logic wr,
                         logic [2:0] idx, logic [31:0] wd, logic ext);
        logic [2:0] eff;
        logic ud, bd, go, bs, bt;
        logic [3:0] en;
        logic [31:0] exp_rd, ns, nc;
        bp_hit = hit; step_done = sd; trap_flag = tf; task_sw = tsw;
        task_trap = ttr; dr_vld = vld; dr_wr = wr; dr_idx = idx;
        dr_wdata = wd; dbg_ext = ext;
        eff = idx;
        if (!ext && idx == 3'd4) eff = 3'd6;
        if (!ext && idx == 3'd5) eff = 3'd7;
        ud = vld && ext && (idx == 3'd4 || idx == 3'd5);
        bd = vld && !ud && m_ctl[13];
        go = vld && !ud && !bd;
        exp_rd = 0;
        if (go && !wr && eff == 3'd6) exp_rd = m_stat;
        if (go && !wr && eff == 3'd7) exp_rd = m_ctl;
        for (int i = 0; i < 4; i++) en[i] = m_ctl[2*i] | m_ctl[2*i+1];
        bs = sd && tf;
        bt = tsw && ttr;
        ns = (go && wr && eff == 3'd6) ? (wd & 32'h0000_E00F) : m_stat;
        ns = ns | {16'd0, bt, bs, bd, 9'd0, hit};
        nc = (go && wr && eff == 3'd7) ? (wd & 32'h0000_20FF) : m_ctl;
        if (tsw) nc = nc & ~32'h55;
        #1;
        chk(req, "acc_go", {31'd0, acc_go}, {31'd0, go});
        chk(req, "rd_data", rd_data, exp_rd);
        @(posedge clk);
        @(negedge clk);
        m_stat = ns; m_ctl = nc;
        m_exc = (|(hit & en)) || bs || bt || bd;
        m_ud = ud;
        chk(req, "stat", stat_reg, m_stat);
        chk(req, "ctl", ctl_reg, m_ctl);
        chk(req, "dbg_exc", {31'd0, dbg_exc}, {31'd0, m_exc});
        chk(req, "ud_req", {31'd0, ud_req}, {31'd0, m_ud});
        idle_inputs();
    endtask

    task automatic wr_reg(string req, logic [2:0] idx, logic [31:0] v);
        apply(req, 0, 0, 0, 0, 0, 1, 1, idx, v, 0);
    endtask

    task automatic rd_reg(string req, logic [2:0] idx, logic ext);
        apply(req, 0, 0, 0, 0, 0, 1, 0, idx, 0, ext);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        do_reset();

        // R1 R2: every enable byte against every match pattern
        for (int c = 0; c < 256; c++) begin
            for (int h = 0; h < 16; h++) begin
                wr_reg("R2", 3'd7, 32'(c));
                apply("R1", 4'(h), 0, 0, 0, 0, 0, 0, 0, 0, 0);
                wr_reg("R9", 3'd6, 32'h0);
            end
        end

        // R3 R5 R12: task switch over every enable byte, with and without trap bit
        for (int c = 0; c < 256; c++) begin
            for (int t = 0; t < 2; t++) begin
                wr_reg("R3", 3'd7, 32'(c) | 32'hFFFF_0000);
                apply("R5", 0, 0, 0, 1, 1'(t), 0, 0, 0, 0, 0);
                apply("R12", 0, 0, 0, 1, 0, 1, 1, 3'd7, 32'(c) ^ 32'hFF, 0);
                wr_reg("R11", 3'd6, 32'hFFFF_FFFF);
                rd_reg("R11", 3'd6, 0);
                wr_reg("R9", 3'd6, 32'h0);
            end
        end

        // R4: single step combinations
        for (int s = 0; s < 4; s++) begin
            apply("R4", 0, 1'(s), 1'(s >> 1), 0, 0, 0, 0, 0, 0, 0);
            wr_reg("R4", 3'd6, 0);
        end

        // R6 R7 R8: every register number, direction, extension mode and detect enable
        for (int x = 0; x < 2; x++)
            for (int g = 0; g < 2; g++)
                for (int i = 0; i < 8; i++)
                    for (int w = 0; w < 2; w++) begin
                        do_reset();
                        wr_reg("R8", 3'd6, 32'h0000_0005);
                        wr_reg("R8", 3'd7, g ? 32'h0000_2042 : 32'h0000_0042);
                        apply(x ? "R7" : (g ? "R6" : "R8"), 0, 0, 0, 0, 0,
                              1, 1'(w), 3'(i), 32'hFFFF_FFFF, 1'(x));
                        rd_reg("R8", 3'd6, 0);
                    end

        // R10: blocked write, matches, step and trapping task switch together
        do_reset();
        wr_reg("R10", 3'd7, 32'h0000_2001);
        apply("R10", 4'b0011, 1, 1, 1, 1, 1, 1, 3'd7, 32'h0, 0);
        chk("R10", "joint stat", stat_reg, 32'h0000_E003);
        chk("R10", "joint ctl", ctl_reg, 32'h0000_2000);
        apply("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R10", "pulse end", {31'd0, dbg_exc}, 0);

        // R9: sticky, cleared by write, write merged with same-cycle match
        do_reset();
        apply("R9", 4'b1000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) apply("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        apply("R9", 4'b0001, 0, 0, 0, 0, 1, 1, 3'd6, 32'h0000_4000, 0);
        chk("R9", "merge", stat_reg, 32'h0000_4001);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule